// File: doc/BRIEF.md
# Parallel Printer Port Receiver (Peripheral Side)

This block sits at the receiving end of a byte-wide parallel printer link. The host drives an active-low strobe together with eight data lines. The receiver answers with a busy line, an active-low acknowledge pulse and three status lines. Each accepted byte goes to a local consumer over a valid/ready interface. Busy stays high from the first sight of a falling strobe until the consumer has taken the byte and the acknowledge pulse has ended.

All host-driven lines pass through a two-stage synchronizer. The strobe and init lines are accepted only after a minimum low time. The block counts every pulse width in clock cycles, derived from a `CLK_HZ` parameter and a width in nanoseconds. The block also reports the host's auto-feed level and flags a qualified init pulse. A qualified init returns the handshake to idle and discards any byte not yet taken.

Top module: `parport_rx`

## Requirements
- R1: After reset, `busy` is 0, `ack_n` is 1, `m_valid` is 0, `host_init` is 0 and `error_n` is 1.
- R2: With the peripheral online and error-free, `busy` goes high at the third rising clock edge after `stb_n` falls. Two edges are for synchronization and one is the output register.
- R3: A strobe is accepted only when it is sampled low on at least STB_CYC = CLK_HZ·STB_MIN_NS/1e9 edges. A shorter low pulse produces no byte, and `busy` returns to 0.
- R4: The byte on `pdata` is captured as the strobe rises. `m_valid` rises at the third edge after `stb_n` goes high. `m_data` and `m_valid` then hold until `m_ready` is seen high.
- R5: At the edge where `m_valid` and `m_ready` are both high, `m_valid` drops and `ack_n` goes low for exactly ACK_CYC = CLK_HZ·ACK_NS/1e9 cycles. `busy` falls at the same edge where `ack_n` returns high.
- R6: `paper_end` follows `paper_out` and `select` follows `online`, one cycle later. `error_n` is low one cycle after any of `fault`, `paper_out` or not `online` is true.
- R7: While any condition from R6 holds, `busy` is high. A strobe that begins during that time produces no byte.
- R8: An `init_n` low for INIT_CYC = CLK_HZ·INIT_MIN_NS/1e9 sampled edges raises `host_init`, drops a pending byte (`m_valid` goes 0) and holds `busy` high. `busy` and `host_init` clear once `init_n` is high again. A shorter init pulse leaves a pending byte in place.
- R9: `autofeed` equals the inverse of `autofd_n`, three edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_n | input | 1 | Host data strobe, active low |
| pdata | input | 8 | Host data lines |
| init_n | input | 1 | Host init request, active low |
| autofd_n | input | 1 | Host auto-feed request, active low |
| busy | output | 1 | Peripheral cannot take data |
| ack_n | output | 1 | Acknowledge pulse, active low |
| paper_end | output | 1 | Paper exhausted |
| select | output | 1 | Peripheral selected/online |
| error_n | output | 1 | Error, offline or paper end, active low |
| paper_out | input | 1 | Local paper-out condition |
| online | input | 1 | Local online/selected condition |
| fault | input | 1 | Local error condition |
| m_valid | output | 1 | Received byte available |
| m_data | output | 8 | Received byte |
| m_ready | input | 1 | Consumer takes the byte |
| autofeed | output | 1 | Host requests auto-feed (level) |
| host_init | output | 1 | Qualified init pulse in progress |

## Verification
Inputs are driven and outputs sampled on falling clock edges, so each latency is counted in whole rising edges. Host-side effects are due at the third edge: `busy` after a strobe falls, `m_valid` after it rises, and `autofeed` after a change. Local status and the acknowledge are due one edge after their cause. Each check samples at that edge and, where the timing matters, also one edge earlier to show the output has not moved yet. Strobe widths of exactly STB_CYC and STB_CYC−1 edges, and init pulses just below and above INIT_CYC, are exercised with a reduced `CLK_HZ`. That keeps the pulse windows short.

// File: rtl/parport_pkg.sv
package parport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOW   = 2'd1,
    ST_OFFER = 2'd2,
    ST_ACK   = 2'd3
  } pp_state_e;

  function automatic int unsigned ns_to_cyc(input longint unsigned clk_hz,
                                            input longint unsigned ns);
    longint unsigned c;
    c = (clk_hz * ns) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '1;
      q  <= '1;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/pp_lowcnt.sv
// Counts consecutive sampled-low cycles of a synchronized level, saturating at N.
module pp_lowcnt #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic long_low
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LIM = CW'(N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || lvl) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign long_low = (cnt == LIM);
endmodule

// File: rtl/pp_hs_fsm.sv
module pp_hs_fsm
  import parport_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ACK_CYC = 50
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          s_stb,
  input  logic          stb_long,
  input  logic [DW-1:0] s_data,
  input  logic          init_long,
  input  logic          hold,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          busy,
  output logic          ack_n
);
  localparam int AW = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;
  localparam logic [AW-1:0] ACK_LOAD = AW'(ACK_CYC - 1);

  pp_state_e     state, nstate;
  logic          stb_prev;
  logic [AW-1:0] ack_cnt;
  logic          stb_fell;

  assign stb_fell = stb_prev & ~s_stb;

  always_comb begin
    nstate = state;
    case (state)
      ST_IDLE:  if (stb_fell && !hold) nstate = ST_LOW;
      ST_LOW:   if (s_stb) nstate = stb_long ? ST_OFFER : ST_IDLE;
      ST_OFFER: if (m_ready) nstate = ST_ACK;
      ST_ACK:   if (ack_cnt == '0) nstate = ST_IDLE;
      default:  nstate = ST_IDLE;
    endcase
    if (init_long) nstate = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      stb_prev <= 1'b1;
      ack_cnt  <= '0;
      m_data   <= '0;
      m_valid  <= 1'b0;
      busy     <= 1'b0;
      ack_n    <= 1'b1;
    end else begin
      state    <= nstate;
      stb_prev <= s_stb;
      m_valid  <= (nstate == ST_OFFER);
      ack_n    <= (nstate != ST_ACK);
      busy     <= (nstate != ST_IDLE) | hold | init_long;
      if (state == ST_LOW && nstate == ST_OFFER) m_data <= s_data;
      if (state == ST_OFFER && nstate == ST_ACK) ack_cnt <= ACK_LOAD;
      else if (state == ST_ACK && ack_cnt != '0) ack_cnt <= ack_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/parport_rx.sv
module parport_rx
  import parport_pkg::*;
#(
  parameter longint unsigned CLK_HZ      = 250_000_000,
  parameter int              DW          = 8,
  parameter int              STB_MIN_NS  = 500,
  parameter int              ACK_NS      = 5000,
  parameter int              INIT_MIN_NS = 50000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic [DW-1:0] pdata,
  input  logic          init_n,
  input  logic          autofd_n,
  output logic          busy,
  output logic          ack_n,
  output logic          paper_end,
  output logic          select,
  output logic          error_n,
  input  logic          paper_out,
  input  logic          online,
  input  logic          fault,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  input  logic          m_ready,
  output logic          autofeed,
  output logic          host_init
);
  localparam int STB_CYC  = ns_to_cyc(CLK_HZ, STB_MIN_NS);
  localparam int ACK_CYC  = ns_to_cyc(CLK_HZ, ACK_NS);
  localparam int INIT_CYC = ns_to_cyc(CLK_HZ, INIT_MIN_NS);
  localparam int SW       = DW + 3;

  logic [SW-1:0] s_vec;
  logic          s_stb, s_init, s_afd;
  logic [DW-1:0] s_data;
  logic          stb_long, init_long;
  logic          hold;

  pp_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pdata, autofd_n, init_n, stb_n}),
    .q   (s_vec)
  );

  assign s_stb  = s_vec[0];
  assign s_init = s_vec[1];
  assign s_afd  = s_vec[2];
  assign s_data = s_vec[SW-1:3];

  pp_lowcnt #(.N(STB_CYC)) u_stb_q (
    .clk (clk), .rst (rst), .lvl (s_stb), .long_low (stb_long)
  );

  pp_lowcnt #(.N(INIT_CYC)) u_init_q (
    .clk (clk), .rst (rst), .lvl (s_init), .long_low (init_long)
  );

  assign hold      = paper_out | ~online | fault;
  assign host_init = init_long;

  pp_hs_fsm #(.DW(DW), .ACK_CYC(ACK_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .s_stb     (s_stb),
    .stb_long  (stb_long),
    .s_data    (s_data),
    .init_long (init_long),
    .hold      (hold),
    .m_ready   (m_ready),
    .m_valid   (m_valid),
    .m_data    (m_data),
    .busy      (busy),
    .ack_n     (ack_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      paper_end <= 1'b0;
      select    <= 1'b0;
      error_n   <= 1'b1;
      autofeed  <= 1'b0;
    end else begin
      paper_end <= paper_out;
      select    <= online;
      error_n   <= ~hold;
      autofeed  <= ~s_afd;
    end
  end
endmodule

// File: rtl/parport_rx_chk.sv
module parport_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          ack_n,
  input logic          m_valid,
  input logic [DW-1:0] m_data,
  input logic          m_ready,
  input logic          host_init
);
  // R4
  valid_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> busy);

  // R5
  ack_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> busy);

  // R5
  no_valid_during_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_valid && !ack_n));

  // R5
  ack_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n) |-> $past(m_valid && m_ready));

  // R4
  offer_held_chk: assert property (@(posedge clk) disable iff (rst || host_init)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R2
  valid_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $past(busy));
endmodule

bind parport_rx parport_rx_chk #(.DW(DW)) u_parport_rx_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .ack_n     (ack_n),
  .m_valid   (m_valid),
  .m_data    (m_data),
  .m_ready   (m_ready),
  .host_init (host_init)
);

// File: tb/test_parport_rx.sv
module test_parport_rx;
  localparam longint unsigned CLK_HZ = 10_000_000;
  localparam int STB  = 5;
  localparam int ACK  = 50;
  localparam int INIT = 500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb_n = 1'b1, init_n = 1'b1, autofd_n = 1'b1;
  logic [7:0] pdata = 8'h00;
  logic paper_out = 1'b0, online = 1'b1, fault = 1'b0, m_ready = 1'b0;
  logic busy, ack_n, paper_end, select, error_n, m_valid, autofeed, host_init;
  logic [7:0] m_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  parport_rx #(.CLK_HZ(CLK_HZ)) i_parport_rx (
    .clk(clk), .rst(rst), .stb_n(stb_n), .pdata(pdata), .init_n(init_n),
    .autofd_n(autofd_n), .busy(busy), .ack_n(ack_n), .paper_end(paper_end),
    .select(select), .error_n(error_n), .paper_out(paper_out), .online(online),
    .fault(fault), .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready),
    .autofeed(autofeed), .host_init(host_init)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // strobe low for n sampled edges, then high
  task automatic strobe(input logic [7:0] b, input int n);
    pdata = b;
    stb_n = 1'b0;
    tick(n);
    stb_n = 1'b1;
  endtask

  task automatic t_reset;
    tick(1);
    chk(busy == 0, "R1", "busy", busy, 0);
    chk(ack_n == 1, "R1", "ack_n", ack_n, 1);
    chk(m_valid == 0, "R1", "m_valid", m_valid, 0);
    chk(host_init == 0, "R1", "host_init", host_init, 0);
    chk(error_n == 1, "R1", "error_n", error_n, 1);
  endtask

  task automatic t_byte(input logic [7:0] b, input int hold_ready);
    pdata = b;
    stb_n = 1'b0;
    tick(2);
    chk(busy == 0, "R2", "busy before 3rd edge", busy, 0);
    tick(1);
    chk(busy == 1, "R2", "busy at 3rd edge", busy, 1);
    tick(STB + 1);
    stb_n = 1'b1;
    tick(2);
    chk(m_valid == 0, "R4", "valid before 3rd edge", m_valid, 0);
    tick(1);
    chk(m_valid == 1, "R4", "valid at 3rd edge", m_valid, 1);
    pdata = ~b;
    tick(hold_ready);
    chk(m_valid == 1 && m_data == b, "R4", "held byte", m_data, b);
    m_ready = 1'b1;
    tick(1);
    m_ready = 1'b0;
    chk(m_valid == 0 && ack_n == 0, "R5", "ack starts", ack_n, 0);
    begin
      int lowc = 1;
      while (ack_n == 0 && lowc < 4 * ACK) begin
        chk(busy == 1, "R5", "busy during ack", busy, 1);
        tick(1);
        if (ack_n == 0) lowc++;
      end
      chk(lowc == ACK, "R5", "ack width", lowc, ACK);
      chk(busy == 0, "R5", "busy falls with ack", busy, 0);
    end
  endtask

  task automatic t_glitch;
    strobe(8'h77, STB - 1);
    tick(6);
    chk(m_valid == 0, "R3", "short strobe no byte", m_valid, 0);
    chk(busy == 0, "R3", "short strobe busy clears", busy, 0);
  endtask

  task automatic t_exact;
    strobe(8'h5A, STB);
    tick(3);
    chk(m_valid == 1 && m_data == 8'h5A, "R3", "min-width strobe accepted", m_data, 8'h5A);
    m_ready = 1'b1;
    tick(1);
    m_ready = 1'b0;
    tick(ACK + 2);
  endtask

  task automatic t_status;
    paper_out = 1'b1;
    tick(1);
    chk(paper_end == 1, "R6", "paper_end", paper_end, 1);
    chk(error_n == 0, "R6", "error_n on paper", error_n, 0);
    chk(busy == 1, "R7", "busy on paper", busy, 1);
    strobe(8'h11, STB + 3);
    tick(6);
    chk(m_valid == 0, "R7", "strobe ignored while held", m_valid, 0);
    paper_out = 1'b0;
    online = 1'b0;
    tick(1);
    chk(select == 0 && paper_end == 0, "R6", "select drops", select, 0);
    chk(error_n == 0 && busy == 1, "R7", "offline busy", busy, 1);
    online = 1'b1;
    fault = 1'b1;
    tick(1);
    chk(select == 1 && error_n == 0, "R6", "fault error_n", error_n, 0);
    fault = 1'b0;
    tick(1);
    chk(error_n == 1 && busy == 0, "R7", "all clear", busy, 0);
  endtask

  task automatic t_init;
    strobe(8'hC3, STB + 2);
    tick(3);
    chk(m_valid == 1, "R8", "byte pending", m_valid, 1);
    init_n = 1'b0;
    tick(INIT - 2);
    init_n = 1'b1;
    tick(4);
    chk(m_valid == 1 && host_init == 0, "R8", "short init keeps byte", m_valid, 1);
    init_n = 1'b0;
    tick(INIT + 4);
    chk(host_init == 1, "R8", "host_init", host_init, 1);
    chk(m_valid == 0, "R8", "byte dropped", m_valid, 0);
    chk(busy == 1, "R8", "busy in init", busy, 1);
    init_n = 1'b1;
    tick(4);
    chk(host_init == 0 && busy == 0, "R8", "init released", busy, 0);
  endtask

  task automatic t_autofeed;
    autofd_n = 1'b0;
    tick(2);
    chk(autofeed == 0, "R9", "autofeed before 3rd edge", autofeed, 0);
    tick(1);
    chk(autofeed == 1, "R9", "autofeed set", autofeed, 1);
    autofd_n = 1'b1;
    tick(3);
    chk(autofeed == 0, "R9", "autofeed clear", autofeed, 0);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    t_reset();
    t_byte(8'hA5, 0);
    t_byte(8'h3C, 7);
    t_byte(8'hFF, 2);
    t_byte(8'h00, 1);
    t_glitch();
    t_exact();
    t_status();
    t_init();
    t_autofeed();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule